// File: doc/BRIEF.md
# Multi-lane SDR/DTR Field Serializer

This block sends one loaded field of 1 to 4 bytes to a serial flash device over 1, 2, 4 or 8 data lines. The field may be an address or a set of mode-control bytes. A controller that sequences the phases presents the field value, a byte count, a lane-mode code and a double-rate flag, then pulses `start`. The block drives the selected lanes, enables only those lanes, produces the serial clock for the phase and pulses `done` when the last group of bits has left.

The block's clock runs at twice the serial clock rate, so one system cycle is one half of a serial clock period. In single-rate (SDR) mode each group of bits is held for a full serial clock, which is two system cycles: the serial clock is low in the first cycle and high in the second. In double-rate (DTR) mode a new group goes out on every edge of the serial clock, so it changes every system cycle. Bits map to lanes in a fixed way. A half-width nibble in dual mode can therefore be sent by padding a byte and using quad mode. No extra mode is needed for it.

Chip select, phase ordering and data reception are handled outside this block.

Top module: `fls_serializer`

## Requirements
- R1: While reset is held, and in every idle cycle after it, `lane_out`, `lane_oe`, `sck_o` and `done` are all 0.
- R2: `lane_mode` 001, 010, 011 and 100 select 1, 2, 4 and 8 lanes, always starting at lane 0. Code 000 means the phase is absent, and codes 101 to 111 are handled the same way. A start with an absent code drives no lane and no clock, and it raises `done` in the next cycle.
- R3: The field holds `size_code`+1 bytes, taken from the low end of `field_in`, and the most significant byte goes first. With N field bits and L lanes, group g (counting from 0) drives bit N-(g+1)*L+j of the field on lane j, so bits go out most significant first.
- R4: The byte 0x8A sent in quad mode with `size_code`=00 holds lane 3 at 1 and lane 2 at 0 in both groups. Lanes 1:0 carry 00 in the first group and 10 in the second, which together form the nibble 0010.
- R5: In SDR mode each group is held for two system cycles, and `sck_o` is low in the first and high in the second. A phase lasts bytes*8/L serial clocks. `sck_o` is low whenever the block is idle.
- R6: In DTR mode each group lasts one system cycle and `sck_o` toggles every cycle, starting low. A phase lasts bytes*8/L/2 serial clocks.
- R7: While a phase runs, `lane_oe` is 1 on lanes 0 to L-1 and 0 on all others. Inactive lanes drive 0 on `lane_out`.
- R8: `done` is high for exactly one cycle, the cycle right after the last group.
- R9: A `start` pulse that arrives while a phase runs is ignored. The phase that is running and its outputs do not change.
- R10: The first group appears in the cycle after `start` is accepted. A start is accepted in any cycle in which no phase runs, and that includes the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, sampled when idle |
| field_in | input | 32 | Field value, right-aligned |
| size_code | input | 2 | Byte count minus one |
| lane_mode | input | 3 | Lane-width code |
| dtr_en | input | 1 | Double-rate select |
| lane_out | output | 8 | Data on each lane |
| lane_oe | output | 8 | Output enable for each lane |
| sck_o | output | 1 | Serial clock for the phase |
| done | output | 1 | One-cycle pulse after the last group |

## Verification
If the shift store holds a wrong value, a wrong bit shows up on some lane in the very group that uses it. The cycle-accurate model catches it at the next falling-edge sample. A fault in the group counter or the phase bit changes the length of the phase. That shows up as a missing, early or late `done`, or as a glitch on `sck_o`, within one cycle of the expected end. A lane count latched wrongly shows at once as a wrong `lane_oe` mask in the first group.

// File: rtl/fls_pkg.sv
package fls_pkg;

  localparam int LANE_MAX = 8;

  localparam logic [2:0] LM_NONE = 3'd0;
  localparam logic [2:0] LM_X1   = 3'd1;
  localparam logic [2:0] LM_X2   = 3'd2;
  localparam logic [2:0] LM_X4   = 3'd3;
  localparam logic [2:0] LM_X8   = 3'd4;

  // number of lanes driven for a mode code; 0 means phase absent
  function automatic logic [3:0] lanes_of(input logic [2:0] code);
    case (code)
      LM_X1:   lanes_of = 4'd1;
      LM_X2:   lanes_of = 4'd2;
      LM_X4:   lanes_of = 4'd4;
      LM_X8:   lanes_of = 4'd8;
      default: lanes_of = 4'd0;
    endcase
  endfunction

  // log2 of the lane count, used to divide bit count into groups
  function automatic logic [1:0] lanes_log2(input logic [2:0] code);
    case (code)
      LM_X2:   lanes_log2 = 2'd1;
      LM_X4:   lanes_log2 = 2'd2;
      LM_X8:   lanes_log2 = 2'd3;
      default: lanes_log2 = 2'd0;
    endcase
  endfunction

  // contiguous enable mask starting at lane 0
  function automatic logic [LANE_MAX-1:0] oe_mask(input logic [3:0] lanes);
    case (lanes)
      4'd1:    oe_mask = 8'h01;
      4'd2:    oe_mask = 8'h03;
      4'd4:    oe_mask = 8'h0F;
      4'd8:    oe_mask = 8'hFF;
      default: oe_mask = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/fls_shift_store.sv
module fls_shift_store #(
  parameter int FIELD_W = 32,
  parameter int SH_W    = $clog2(FIELD_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [FIELD_W-1:0] field,
  input  logic [SH_W-1:0]    nbits,
  input  logic [3:0]         lanes,
  output logic [7:0]         top_byte
);

  logic [FIELD_W-1:0] sreg;
  logic [SH_W-1:0]    align_amt;

  // left-align the used bytes so the first bit to send sits at the top
  assign align_amt = SH_W'(FIELD_W) - nbits;
  assign top_byte  = sreg[FIELD_W-1 -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
    end else if (load) begin
      sreg <= field << align_amt;
    end else if (shift) begin
      sreg <= sreg << lanes;
    end
  end

endmodule

// File: rtl/fls_lane_map.sv
module fls_lane_map #(
  parameter int LANE_N = 8
) (
  input  logic              active,
  input  logic [3:0]        lanes,
  input  logic [7:0]        top_byte,
  output logic [LANE_N-1:0] lane_d
);

  // lane j of an L-lane group carries bit (8-L+j) of the leading byte;
  // modulo 8 that index is j-L, which a 3-bit subtract yields directly
  for (genvar j = 0; j < LANE_N; j++) begin : g_lane
    logic [2:0] idx;
    logic       used;
    assign idx       = 3'(j) - lanes[2:0];
    assign used      = active && (4'(j) < lanes);
    assign lane_d[j] = used && top_byte[idx];
  end

endmodule

// File: rtl/fls_seq.sv
module fls_seq #(
  parameter int GRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_ok,
  input  logic             dtr,
  input  logic [GRP_W-1:0] grp_total,
  output logic             busy,
  output logic             ph,
  output logic             dtr_q,
  output logic             done,
  output logic             accept,
  output logic             load,
  output logic             advance,
  output logic             last,
  output logic             shift
);

  logic [GRP_W-1:0] grp_left;

  assign accept  = start && !busy;
  assign load    = accept && mode_ok;
  // a group ends every cycle in DTR, every second cycle in SDR
  assign advance = busy && (dtr_q || ph);
  assign last    = advance && (grp_left == '0);
  assign shift   = advance && !last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ph       <= 1'b0;
      dtr_q    <= 1'b0;
      done     <= 1'b0;
      grp_left <= '0;
    end else begin
      done <= (accept && !mode_ok) || last;
      if (load) begin
        busy     <= 1'b1;
        ph       <= 1'b0;
        dtr_q    <= dtr;
        grp_left <= grp_total - GRP_W'(1);
      end else if (busy) begin
        ph <= !ph;
        if (last) begin
          busy <= 1'b0;
          ph   <= 1'b0;
        end else if (advance) begin
          grp_left <= grp_left - GRP_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/fls_serializer.sv
module fls_serializer #(
  parameter int MAX_BYTES = 4,
  parameter int LANE_N    = 8,
  localparam int FIELD_W  = 8 * MAX_BYTES,
  localparam int SIZE_W   = $clog2(MAX_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FIELD_W-1:0] field_in,
  input  logic [SIZE_W-1:0]  size_code,
  input  logic [2:0]         lane_mode,
  input  logic               dtr_en,
  output logic [LANE_N-1:0]  lane_out,
  output logic [LANE_N-1:0]  lane_oe,
  output logic               sck_o,
  output logic               done
);

  import fls_pkg::*;

  localparam int NB_W  = SIZE_W + 1;
  localparam int SH_W  = $clog2(FIELD_W + 1);
  localparam int GRP_W = $clog2(FIELD_W + 1);

  // named internal events, observed by the bound checker
  logic             busy_w;
  logic             ph_w;
  logic             dtr_q_w;
  logic             accept_w;
  logic             load_w;
  logic             advance_w;
  logic             last_w;
  logic             shift_w;

  logic [NB_W-1:0]  nbytes;
  logic [SH_W-1:0]  nbits;
  logic [3:0]       lanes_in;
  logic [3:0]       lanes_q;
  logic             mode_ok;
  logic [GRP_W-1:0] grp_total;
  logic [7:0]       top_byte;

  assign nbytes    = NB_W'(size_code) + NB_W'(1);
  assign nbits     = SH_W'({nbytes, 3'b000});
  assign lanes_in  = lanes_of(lane_mode);
  assign mode_ok   = (lanes_in != 4'd0);
  assign grp_total = GRP_W'(nbits >> lanes_log2(lane_mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lanes_q <= 4'd0;
    end else if (load_w) begin
      lanes_q <= lanes_in;
    end
  end

  fls_seq #(.GRP_W(GRP_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_ok   (mode_ok),
    .dtr       (dtr_en),
    .grp_total (grp_total),
    .busy      (busy_w),
    .ph        (ph_w),
    .dtr_q     (dtr_q_w),
    .done      (done),
    .accept    (accept_w),
    .load      (load_w),
    .advance   (advance_w),
    .last      (last_w),
    .shift     (shift_w)
  );

  fls_shift_store #(.FIELD_W(FIELD_W), .SH_W(SH_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_w),
    .shift    (shift_w),
    .field    (field_in),
    .nbits    (nbits),
    .lanes    (lanes_q),
    .top_byte (top_byte)
  );

  fls_lane_map #(.LANE_N(LANE_N)) u_map (
    .active   (busy_w),
    .lanes    (lanes_q),
    .top_byte (top_byte),
    .lane_d   (lane_out)
  );

  assign lane_oe = busy_w ? LANE_N'(oe_mask(lanes_q)) : '0;
  assign sck_o   = busy_w && ph_w;

endmodule

// File: rtl/fls_serializer_chk.sv
module fls_serializer_chk #(
  parameter int LANE_N = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LANE_N-1:0] lane_out,
  input logic [LANE_N-1:0] lane_oe,
  input logic              sck_o,
  input logic              done,
  input logic              busy,
  input logic              dtr_q,
  input logic              last
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lane_oe == '0 && lane_out == '0 && !sck_o)); // R1

  AST_OE_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_oe & (lane_oe + LANE_N'(1))) == '0)); // R7

  AST_OUT_WITHIN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_out & ~lane_oe) == '0)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8

  AST_SDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dtr_q && !sck_o) |=> (busy && sck_o && $stable(lane_out))); // R5

  AST_DTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dtr_q && !last) |=> (sck_o != $past(sck_o))); // R6

  AST_RUN_UNDISTURBED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(lane_oe))); // R9

endmodule

bind fls_serializer fls_serializer_chk #(.LANE_N(LANE_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .lane_out (lane_out),
  .lane_oe  (lane_oe),
  .sck_o    (sck_o),
  .done     (done),
  .busy     (busy_w),
  .dtr_q    (dtr_q_w),
  .last     (last_w)
);

// File: tb/fls_serializer_test.sv
`timescale 1ns/1ps
module fls_serializer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] field_in = '0;
  logic [1:0]  size_code = '0;
  logic [2:0]  lane_mode = '0;
  logic        dtr_en = 1'b0;
  logic [7:0]  lane_out;
  logic [7:0]  lane_oe;
  logic        sck_o;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;

  // expected per cycle: {data[7:0], oe[7:0], sck, done}
  logic [17:0] exp_q[$];
  string       dtag_q[$];
  string       stag_q[$];

  always #2.5 clk = ~clk;

  fls_serializer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .field_in  (field_in),
    .size_code (size_code),
    .lane_mode (lane_mode),
    .dtr_en    (dtr_en),
    .lane_out  (lane_out),
    .lane_oe   (lane_oe),
    .sck_o     (sck_o),
    .done      (done)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    logic [17:0] e;
    string dt, st;
    cyc++;
    if (model_on) begin
      if (exp_q.size() > 0) begin
        e  = exp_q.pop_front();
        dt = dtag_q.pop_front();
        st = stag_q.pop_front();
      end else begin
        e  = '0;
        dt = "R1";
        st = "R1";
      end
      chk(dt, lane_out, e[17:10]);
      chk("R7", lane_oe, e[9:2]);
      chk(st, {7'd0, sck_o}, {7'd0, e[1]});
      chk("R8", {7'd0, done}, {7'd0, e[0]});
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  function automatic int lanes_for(input logic [2:0] m);
    case (m)
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return 4;
      3'd4: return 8;
      default: return 0;
    endcase
  endfunction

  // push the expected waveform for one launched phase
  task automatic model_push(input logic [31:0] f, input logic [1:0] sz,
                            input logic [2:0] m, input logic d, input string tag);
    int nl, nb, ng;
    logic [7:0] dat, oe;
    nl = lanes_for(m);
    if (nl == 0) begin
      exp_q.push_back(18'b1);
      dtag_q.push_back("R2");
      stag_q.push_back("R2");
      return;
    end
    nb = (int'(sz) + 1) * 8;
    ng = nb / nl;
    oe = 8'((1 << nl) - 1);
    for (int g = 0; g < ng; g++) begin
      dat = '0;
      for (int j = 0; j < nl; j++) dat[j] = f[nb - (g + 1) * nl + j];
      if (d) begin
        exp_q.push_back({dat, oe, 1'(g % 2), 1'b0});
        dtag_q.push_back(tag); stag_q.push_back("R6");
      end else begin
        exp_q.push_back({dat, oe, 1'b0, 1'b0});
        dtag_q.push_back(tag); stag_q.push_back("R5");
        exp_q.push_back({dat, oe, 1'b1, 1'b0});
        dtag_q.push_back(tag); stag_q.push_back("R5");
      end
    end
    exp_q.push_back(18'b1);
    dtag_q.push_back("R8");
    stag_q.push_back("R5");
  endtask

  task automatic wait_empty();
    forever begin
      @(negedge clk); #1;
      if (exp_q.size() == 0) break;
    end
  endtask

  task automatic launch(input logic [31:0] f, input logic [1:0] sz,
                        input logic [2:0] m, input logic d, input string tag);
    wait_empty();
    field_in = f; size_code = sz; lane_mode = m; dtr_en = d;
    start = 1'b1;
    model_push(f, sz, m, d, tag);
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    wait_empty();
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    logic [7:0] q0, q1;
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    chk("R1", lane_out, 8'h00);
    chk("R1", lane_oe, 8'h00);
    chk("R1", {6'd0, sck_o, done}, 8'h00);
    #1 rst_n = 1'b1;
    model_on = 1'b1;
    idle(2);

    // R4: check the padded-nibble byte against literal lane values
    q0 = '0; q1 = '0;
    for (int j = 0; j < 4; j++) begin
      q0[j] = 8'h8A >> (4 + j);
      q1[j] = 8'h8A >> j;
    end
    chk("R4", q0, 8'h08);
    chk("R4", q1, 8'h0A);
    launch(32'h0000_008A, 2'd0, 3'd3, 1'b0, "R4");

    launch(32'h0000_00A5, 2'd0, 3'd1, 1'b0, "R3");    // R3 single SDR 1 byte
    launch(32'hFFFF_C36E, 2'd1, 3'd2, 1'b0, "R3");    // R3 dual SDR 2 bytes
    launch(32'h1234_5678, 2'd3, 3'd4, 1'b0, "R3");    // R3 octal SDR 4 bytes
    idle(3);
    launch(32'h00_9D_3C_E1, 2'd2, 3'd1, 1'b1, "R6");  // R6 single DTR 3 bytes
    launch(32'hDEAD_BEEF, 2'd3, 3'd3, 1'b1, "R6");    // R6 quad DTR 4 bytes
    launch(32'h0000_005C, 2'd0, 3'd4, 1'b1, "R6");    // R6 octal DTR 1 byte
    launch(32'h0000_0B71, 2'd1, 3'd2, 1'b1, "R6");    // R6 dual DTR 2 bytes
    idle(2);

    launch(32'hFFFF_FFFF, 2'd3, 3'd0, 1'b0, "R2");    // R2 absent code
    idle(1);
    launch(32'hFFFF_FFFF, 2'd3, 3'd5, 1'b1, "R2");    // R2 unused code
    launch(32'h0000_00F0, 2'd0, 3'd7, 1'b0, "R2");    // R2 unused code
    idle(2);

    // R9: start pulse with new inputs during a long run
    launch(32'h0000_1234, 2'd1, 3'd1, 1'b0, "R9");
    @(negedge clk); #1;
    field_in = 32'hFFFF_FFFF; size_code = 2'd3; lane_mode = 3'd4; dtr_en = 1'b1;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;

    // R10: launch in the done cycle of the previous run
    launch(32'h00AB_CDEF, 2'd2, 3'd3, 1'b0, "R10");
    launch(32'h0000_0081, 2'd0, 3'd2, 1'b1, "R10");
    idle(4);
    summary();
  end

endmodule